// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This controller classifies every erase block of a NAND array when the system starts. A pulse on `start` makes it step through the blocks in ascending order. For each block it asks a lower-level page-read sequencer for a single byte: the first byte after the main data area of the block's first page, and, when that byte reads FFh, the same byte of the block's second page. A block counts as defective when either byte differs from FFh. Block 0 is always good, so the scanner never reads it.

The result of each block goes into an internal one-bit-per-block map. Software or a wear-levelling engine reads the map through a lookup port with one cycle of latency. A running defect count and a completion flag are outputs. An erase-inhibit output stays high until the scan finishes, because an erase would wipe the factory markers before they are read. After the scan, blocks that fail a program or erase at runtime can be added to the map through a mark port.

Top module: `nand_bbscan`

## Requirements
- R1: After reset, `done` is 0, `erase_inhibit` is 1, `req_valid` is 0, `bad_count` is 0 and every map entry reads 0 (good). The block stays in this state until `start` is seen.
- R2: When `start` is accepted, block 0 is written as good in that same cycle. No request is ever issued for a row below `PAGES_PER_BLOCK`, which means no page of block 0 is read.
- R3: A request has `req_valid` = 1, `req_row` = block × `PAGES_PER_BLOCK` + page, and `req_col` = `PAGE_BYTES` (2048 by default, the first spare column). The request holds with a stable row until a cycle in which `rsp_valid` is 1, and that cycle completes it.
- R4: When the page-0 byte is not FFh, the block is recorded bad and its page 1 is not requested. The next request is page 0 of the following block.
- R5: When the page-0 byte is FFh, the next request is page 1 (row + 1) of the same block. The block is recorded bad exactly when that byte is not FFh.
- R6: `done` rises in the cycle after the response that completes the last block (index `NUM_BLOCKS`-1). It then stays high, and no request is issued while it is high. `erase_inhibit` is the inverse of `done`.
- R7: `bad_count` equals the number of entries that scanning has set to bad. It is cleared when a scan starts.
- R8: `lookup_bad` shows the map entry for `lookup_idx`, registered one clock after the index is presented. A write in the same cycle is not yet visible.
- R9: A `mark_valid` pulse while `done` is 1 sets entry `mark_idx` to bad. It raises `bad_count` by one only if that entry was good. The pulse is ignored while `done` is 0, and also in a cycle in which a new scan is accepted.
- R10: `start` while a scan is running has no effect. `start` while `done` is 1 clears the count and rescans, overwriting every entry, including entries that were marked at runtime.
- R11: `rsp_valid` with no request outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (pulse) |
| req_valid | output | 1 | Spare-byte read request pending |
| req_row | output | clog2(NUM_BLOCKS)+clog2(PAGES_PER_BLOCK) | Page row to read |
| req_col | output | clog2(PAGE_BYTES+SPARE_BYTES) | Column to read |
| rsp_valid | input | 1 | Read byte returned; completes the request |
| rsp_data | input | 8 | Returned byte |
| lookup_idx | input | clog2(NUM_BLOCKS) | Block index to look up |
| lookup_bad | output | 1 | Map entry of the previous cycle's index, 1 = bad |
| mark_valid | input | 1 | Record a runtime failure |
| mark_idx | input | clog2(NUM_BLOCKS) | Block to mark bad |
| bad_count | output | clog2(NUM_BLOCKS+1) | Number of bad entries |
| done | output | 1 | Scan complete |
| erase_inhibit | output | 1 | Erases must not be issued |

## Verification
The hardest cases to reach are the ones where one event meets a particular scan state. Examples are a block whose page-1 byte is the only defective marker, which must be reached through an FFh on page 0, a second `start` that lands in the middle of a scan, and a runtime mark aimed at an entry that a rescan will overwrite. The bench sets the spare bytes of both pages per block, including bytes on block 0 that must never be fetched. It answers each request after a delay of zero to three cycles that depends on block and page, which exercises both same-cycle completion and held requests. It fires the stray start, the early mark and the stray response at chosen scan cycles. Its behavioural model follows every cycle, so a wrong row, an extra page-1 read or a miscounted defect appears at the cycle it happens.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_READ = 2'd1,
        SCAN_DONE = 2'd2
    } scan_state_e;

    localparam logic [7:0] GOOD_MARK = 8'hFF;
endpackage

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
    parameter int NUM_BLOCKS = 1024,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bad,
    input  logic [BLK_W-1:0] peek_idx,
    output logic             peek_bad
);
    localparam logic [BLK_W:0] LIMIT = (BLK_W+1)'(NUM_BLOCKS);

    logic [NUM_BLOCKS-1:0] map_d, map_q;
    logic                  rd_d, rd_q;

    always_comb begin
        map_d = map_q;
        if (wr_en && ({1'b0, wr_idx} < LIMIT)) begin
            map_d[wr_idx] = wr_bad;
        end
        rd_d     = ({1'b0, rd_idx} < LIMIT) ? map_q[rd_idx] : 1'b0;
        peek_bad = ({1'b0, peek_idx} < LIMIT) ? map_q[peek_idx] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
            rd_q  <= 1'b0;
        end else begin
            map_q <= map_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_bad = rd_q;
endmodule

// File: rtl/bbs_walker.sv
module bbs_walker
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 1024,
    parameter int BLK_W      = $clog2(NUM_BLOCKS),
    parameter int PG_W       = 6,
    parameter int COL_W      = 12,
    parameter int SPARE_COL  = 2048
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  rsp_valid,
    input  logic [7:0]            rsp_data,
    output logic                  req_valid,
    output logic [BLK_W+PG_W-1:0] req_row,
    output logic [COL_W-1:0]      req_col,
    output logic                  done,
    output logic                  wr_en,
    output logic [BLK_W-1:0]      wr_idx,
    output logic                  wr_bad,
    output logic                  restart
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        scan_state_e      st;
        logic [BLK_W-1:0] blk;
        logic             pg;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  marker_bad;

    always_comb begin
        walk_d     = walk_q;
        wr_en      = 1'b0;
        wr_idx     = walk_q.blk;
        wr_bad     = 1'b0;
        restart    = 1'b0;
        marker_bad = (rsp_data != GOOD_MARK);
        case (walk_q.st)
            SCAN_READ: begin
                if (rsp_valid) begin
                    if (marker_bad || walk_q.pg) begin
                        wr_en     = 1'b1;
                        wr_bad    = marker_bad;
                        walk_d.pg = 1'b0;
                        if (walk_q.blk == LAST_BLK) begin
                            walk_d.st = SCAN_DONE;
                        end else begin
                            walk_d.blk = walk_q.blk + 1'b1;
                        end
                    end else begin
                        walk_d.pg = 1'b1;
                    end
                end
            end
            default: begin
                if (start) begin
                    restart    = 1'b1;
                    wr_en      = 1'b1;
                    wr_idx     = '0;
                    walk_d.st  = SCAN_READ;
                    walk_d.blk = BLK_W'(1);
                    walk_d.pg  = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: SCAN_IDLE, blk: '0, pg: 1'b0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_valid = (walk_q.st == SCAN_READ);
    assign req_row   = {walk_q.blk, PG_W'(walk_q.pg)};
    assign req_col   = COL_W'(SPARE_COL);
    assign done      = (walk_q.st == SCAN_DONE);
endmodule

// File: rtl/nand_bbscan.sv
module nand_bbscan #(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_BYTES      = 2048,
    parameter int SPARE_BYTES     = 64
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  start,
    output logic                                                  req_valid,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] req_row,
    output logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0]             req_col,
    input  logic                                                  rsp_valid,
    input  logic [7:0]                                            rsp_data,
    input  logic [$clog2(NUM_BLOCKS)-1:0]                         lookup_idx,
    output logic                                                  lookup_bad,
    input  logic                                                  mark_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0]                         mark_idx,
    output logic [$clog2(NUM_BLOCKS+1)-1:0]                       bad_count,
    output logic                                                  done,
    output logic                                                  erase_inhibit
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK);
    localparam int COL_W = $clog2(PAGE_BYTES + SPARE_BYTES);
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1);

    logic             scan_we, scan_bad, restart;
    logic [BLK_W-1:0] scan_idx;
    logic             mark_ok, mark_was_bad;
    logic             map_we, map_bad;
    logic [BLK_W-1:0] map_idx;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    bbs_walker #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .PG_W       (PG_W),
        .COL_W      (COL_W),
        .SPARE_COL  (PAGE_BYTES)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .req_valid (req_valid),
        .req_row   (req_row),
        .req_col   (req_col),
        .done      (done),
        .wr_en     (scan_we),
        .wr_idx    (scan_idx),
        .wr_bad    (scan_bad),
        .restart   (restart)
    );

    bbs_bitmap #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_we),
        .wr_idx   (map_idx),
        .wr_bad   (map_bad),
        .rd_idx   (lookup_idx),
        .rd_bad   (lookup_bad),
        .peek_idx (mark_idx),
        .peek_bad (mark_was_bad)
    );

    always_comb begin
        mark_ok = mark_valid && done && !restart;
        map_we  = scan_we || mark_ok;
        map_idx = scan_we ? scan_idx : mark_idx;
        map_bad = scan_we ? scan_bad : 1'b1;
        cnt_d   = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (scan_we && scan_bad) begin
            cnt_d = cnt_q + 1'b1;
        end else if (mark_ok && !mark_was_bad) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign bad_count     = cnt_q;
    assign erase_inhibit = !done;
endmodule

// File: rtl/bbs_chk.sv
module bbs_chk #(
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_BYTES      = 2048,
    parameter int ROW_W           = 16,
    parameter int PG_W            = 6,
    parameter int COL_W           = 12,
    parameter int CNT_W           = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_valid,
    input logic [ROW_W-1:0] req_row,
    input logic [COL_W-1:0] req_col,
    input logic             rsp_valid,
    input logic [7:0]       rsp_data,
    input logic [CNT_W-1:0] bad_count,
    input logic             done
);
    AST_SKIP_BLOCK0: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_row >= ROW_W'(PAGES_PER_BLOCK)); // R2
    AST_SPARE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_col == COL_W'(PAGE_BYTES)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_row))); // R3
    AST_BAD_MARK_NEXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && rsp_data != 8'hFF) |=> (!req_valid || !req_row[0])); // R4
    AST_GOOD_PAGE0_READS_PAGE1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && rsp_data == 8'hFF && !req_row[0])
        |=> (req_valid && req_row == $past(req_row) + 1'b1)); // R5
    AST_ONLY_TWO_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_row[PG_W-1:1] == '0); // R5
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> (bad_count == $past(bad_count)
                           || bad_count == CNT_W'($past(bad_count) + 1'b1))); // R7
endmodule

bind nand_bbscan bbs_chk #(
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_BYTES      (PAGE_BYTES),
    .ROW_W           (BLK_W + PG_W),
    .PG_W            (PG_W),
    .COL_W           (COL_W),
    .CNT_W           (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_row   (req_row),
    .req_col   (req_col),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .bad_count (bad_count),
    .done      (done)
);

// File: tb/nand_bbscan_tb.sv
module nand_bbscan_tb;
    localparam int NB  = 16;
    localparam int PPB = 64;
    localparam int PB  = 2048;
    localparam int SB  = 64;
    localparam int BW  = 4;
    localparam int RW  = 10;
    localparam int CW  = 12;
    localparam int KW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [7:0]    rsp_data = 8'h00;
    logic          mark_valid = 1'b0;
    logic [BW-1:0] mark_idx = '0;
    logic [BW-1:0] lookup_idx = '0;
    logic          req_valid, lookup_bad, done, erase_inhibit;
    logic [RW-1:0] req_row;
    logic [CW-1:0] req_col;
    logic [KW-1:0] bad_count;

    always #5 clk = ~clk;

    nand_bbscan #(
        .NUM_BLOCKS (NB), .PAGES_PER_BLOCK (PPB), .PAGE_BYTES (PB), .SPARE_BYTES (SB)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .req_valid (req_valid), .req_row (req_row), .req_col (req_col),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .lookup_idx (lookup_idx), .lookup_bad (lookup_bad),
        .mark_valid (mark_valid), .mark_idx (mark_idx),
        .bad_count (bad_count), .done (done), .erase_inhibit (erase_inhibit)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int mk0[NB];
    int mk1[NB];
    int m_map[NB];
    int m_state = 0;
    int m_blk = 0;
    int m_pg = 0;
    int m_count = 0;
    int m_lookup = 0;
    int m_wait = 0;
    bit do_start = 0;
    bit do_mark = 0;
    bit do_stray = 0;
    int mark_sel = 0;
    int look_sel = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int wait_for(int b, int p);
        return (b * 3 + p) % 4;
    endfunction

    function automatic int pattern_bad(int b);
        if (b == 0) return 0;
        return (mk0[b] != 8'hFF || mk1[b] != 8'hFF) ? 1 : 0;
    endfunction

    task automatic compare();
        chk("R3 request valid", int'(req_valid), (m_state == 1) ? 1 : 0);
        if (m_state == 1) begin
            chk("R3 request row", int'(req_row), m_blk * PPB + m_pg);
            chk("R3 request column", int'(req_col), PB);
        end
        chk("R6 done flag", int'(done), (m_state == 2) ? 1 : 0);
        chk("R6 erase inhibit", int'(erase_inhibit), (m_state != 2) ? 1 : 0);
        chk("R7 bad count", int'(bad_count), m_count);
        chk("R8 lookup", int'(lookup_bad), m_lookup);
    endtask

    task automatic step();
        bit       rv;
        logic [7:0] rd;
        int       nb;
        @(negedge clk);
        compare();
        rv = 1'b0;
        rd = 8'h5A ^ 8'(n_chk);
        if (m_state == 1) begin
            if (m_wait == 0) begin
                rv = 1'b1;
                rd = 8'((m_pg == 1) ? mk1[m_blk] : mk0[m_blk]);
            end else begin
                m_wait--;
            end
        end else if (do_stray) begin
            rv = 1'b1;
            rd = 8'h00;
        end
        start      = do_start;
        rsp_valid  = rv;
        rsp_data   = rd;
        mark_valid = do_mark;
        mark_idx   = BW'(mark_sel);
        lookup_idx = BW'(look_sel);
        m_lookup = m_map[look_sel];
        if (do_mark && m_state == 2 && !do_start && m_map[mark_sel] == 0) begin
            m_map[mark_sel] = 1;
            m_count++;
        end
        if (m_state != 1 && do_start) begin
            m_state = 1; m_blk = 1; m_pg = 0; m_map[0] = 0; m_count = 0;
            m_wait = wait_for(1, 0);
        end else if (m_state == 1 && rv) begin
            nb = (rd != 8'hFF) ? 1 : 0;
            if (nb == 1 || m_pg == 1) begin
                m_map[m_blk] = nb;
                m_count += nb;
                m_pg = 0;
                if (m_blk == NB - 1) m_state = 2;
                else m_blk++;
            end else begin
                m_pg = 1;
            end
            m_wait = wait_for(m_blk, m_pg);
        end
        do_start = 0;
        do_mark  = 0;
        do_stray = 0;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic run_scan(bit inject);
        int it = 0;
        do_start = 1;
        step();
        while (m_state != 2 && it < 2000) begin
            look_sel = it % NB;
            if (inject && it == 8) do_mark = 1;
            if (inject && it == 10) mark_sel = 0;
            if (inject && m_blk == 4 && m_pg == 0 && !do_start && it > 2 && it < 30) begin
                do_start = 1;
                step();
                settle();
                chk("R10 start during scan ignored", int'(req_row) >= 4 * PPB ? 1 : 0, 1);
                chk("R6 inhibit high while scanning", int'(erase_inhibit), 1);
            end else begin
                step();
            end
            it++;
        end
    endtask

    task automatic sweep(string tag);
        for (int b = 0; b < NB; b++) begin
            look_sel = b;
            step();
            settle();
            chk(tag, int'(lookup_bad), m_map[b]);
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            mk0[b] = 8'hFF; mk1[b] = 8'hFF; m_map[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset inhibit", int'(erase_inhibit), 1);
        chk("R1 reset request", int'(req_valid), 0);
        chk("R1 reset count", int'(bad_count), 0);
        repeat (3) step();

        do_stray = 1;
        step();
        settle();
        chk("R11 stray response idle", int'(req_valid) + int'(done) + int'(bad_count), 0);
        mark_sel = 4; do_mark = 1;
        step();
        look_sel = 4;
        step();
        settle();
        chk("R9 mark before done ignored", int'(lookup_bad), 0);

        mk0[0] = 8'h00; mk1[0] = 8'h00;
        mk0[3] = 8'h00;
        mk1[5] = 8'hF0;
        mk0[7] = 8'hFE;
        mk0[9] = 8'h00; mk1[9] = 8'h00;
        mk1[15] = 8'h7F;
        mark_sel = 2;
        run_scan(1'b1);
        settle();
        chk("R6 done after last block", int'(done), 1);
        chk("R6 inhibit released", int'(erase_inhibit), 0);
        chk("R7 total defects", int'(bad_count), 5);
        for (int b = 0; b < NB; b++) begin
            look_sel = b;
            step();
            settle();
            if (b == 0) chk("R2 block 0 good", int'(lookup_bad), 0);
            else if (mk0[b] != 8'hFF) chk("R4 page-0 marker", int'(lookup_bad), pattern_bad(b));
            else chk("R5 page-1 marker", int'(lookup_bad), pattern_bad(b));
        end

        do_stray = 1;
        step();
        settle();
        chk("R11 stray response done", int'(bad_count), 5);

        mark_sel = 2; do_mark = 1;
        step();
        settle();
        chk("R9 mark good block", int'(bad_count), 6);
        mark_sel = 3; do_mark = 1;
        step();
        settle();
        chk("R9 mark bad block", int'(bad_count), 6);
        look_sel = 2;
        step();
        settle();
        chk("R9 marked entry", int'(lookup_bad), 1);

        for (int b = 1; b < NB; b++) begin
            mk0[b] = 8'hFF; mk1[b] = 8'hFF;
        end
        run_scan(1'b0);
        settle();
        chk("R10 rescan count", int'(bad_count), 0);
        sweep("R10 rescan entry");
        repeat (3) step();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule